// File: doc/BRIEF.md
# Sector Update Command Sequencer

This block sits behind a byte-stream command decoder on the management side of a card. It receives one host command at a time: a start strobe carries the command code and the transfer length, and the payload bytes that follow come with valid and last strobes. Before it accepts any image data, it requires a fixed order of setup commands. The order is: pick a target flash, then grant the controller write access, then grant the flash write access. Data-block commands may each carry up to 252 bytes. Their payloads are packed back to back into one sector-sized staging buffer, and the block drives that buffer's write port.

A CRC-check command closes the current sector. If the buffer holds exactly one sector, the block starts a background commit to a flash-writer port and hands it the sector address and the 64-bit CRC. The sector address is the sequence number times the sector size. The block reports "check in progress" until the writer answers, then turns the writer's result into a one-byte status code. After a successful commit, the sector sequence number advances by one. The host can also reload the sequence number directly, so that it can resume an interrupted update.

Top module: `sector_update_seq`

## Requirements
- R1: After reset, status_o is 0xFF, target_o is 0x01, seq_o is 0, wr_req_o is 0, and no target counts as selected.
- R2: Command 0x42 with a single payload byte of 0x01 to 0x04 loads that code into target_o, marks the target as selected and gives status 0x01. Any other byte value gives 0x08 and leaves target_o unchanged.
- R3: Command 0x44 takes two payload bytes: a device and a mode. With no target selected it gives 0x23. A device byte that differs from target_o gives 0x08. Mode 0x02 grants controller write access and mode 0x01 revokes it, both with status 0x01. Revoking also revokes flash write access. Any other mode gives 0x02.
- R4: Command 0x45 takes the same two bytes as 0x44 and controls flash write access. Its checks run in this order: no target selected gives 0x23, no controller access gives 0x24, device mismatch gives 0x08, then the mode is applied as for 0x44.
- R5: Command 0x47 is refused at its start strobe when setup is incomplete. The checks run in this order: no target gives 0x23, no controller access gives 0x24, no flash access gives 0x02. A refused command writes none of its bytes.
- R6: Command 0x47 with a length of 0 or a length above 252 is refused with status 0x02, and none of its bytes are written.
- R7: While an accepted 0x47 payload is streaming, status is 0x10. Each byte is written to the buffer at the next fill position, so consecutive transfers pack back to back starting at address 0. When the last byte arrives, status becomes 0x01.
- R8: If a data byte arrives while the buffer already holds SECTOR_BYTES bytes, status becomes 0x0B, the fill position returns to 0, and the rest of that transfer is dropped.
- R9: Command 0x48 carries 8 CRC bytes, least significant byte first. A payload of any other length gives 0x02 and the fill position is kept. If the fill is not exactly SECTOR_BYTES, the result is 0x0B, the fill returns to 0 and no commit starts.
- R10: A valid 0x48 sets status to 0x20 and raises wr_req_o. It presents wr_addr_o equal to seq_o times SECTOR_BYTES and presents the CRC. All three stay held until wr_done_i.
- R11: On wr_done_i the writer result code maps to a status: 0 gives 0x01, 1 gives 0x04, 2 gives 0x05, 3 gives 0x06, 4 gives 0x07, and 5 gives 0x21. In every case the fill position returns to 0.
- R12: seq_o increases by 1 only after a commit with result 0. Command 0x49 with two bytes, low byte first, loads seq_o and gives 0x01. Any other length gives 0x02.
- R13: While a commit is pending, every new command is ignored: status, seq_o, the setup state and the buffer are left untouched.
- R14: Any other command code gives status 0x03, and its payload is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Start of a command; code and length valid |
| cmd_code_i | input | 8 | Command code |
| cmd_len_i | input | 8 | Declared payload length for data blocks |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_data_i | input | 8 | Payload byte |
| pl_last_i | input | 1 | Final payload byte of the command |
| buf_we_o | output | 1 | Staging buffer write enable |
| buf_addr_o | output | OFF_W | Staging buffer byte address |
| buf_data_o | output | 8 | Staging buffer write data |
| wr_req_o | output | 1 | Sector commit request to the flash writer |
| wr_addr_o | output | SEQ_W+OFF_W | Flash byte address of the sector |
| wr_crc_o | output | 64 | Expected sector CRC |
| wr_done_i | input | 1 | Writer finished the commit |
| wr_res_i | input | 3 | Writer result code |
| status_o | output | 8 | Current status code |
| target_o | output | 8 | Selected target device code |
| seq_o | output | SEQ_W | Sector sequence number |

## Verification
The embedded assertions check several things on every clock. A buffer write never happens without all three setup grants and never happens during a pending commit. The fill never exceeds one sector, and a commit only starts from a full buffer. A request and its address hold until the writer answers. Flash access never outlives controller access, and the sequence number moves only by a successful commit or by an idle reload. Several other behaviours can only be shown by the bench's scenarios: the exact status code chosen for each refusal, the mapping from writer results to codes, the packing of short transfers into consecutive addresses, the overflow and wrong-length paths, and the silence of commands sent while a commit is pending.

// File: rtl/fus_pkg.sv
package fus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_TGT, PH_CWE, PH_FWE, PH_DATA, PH_CRC, PH_SEQ, PH_SKIP
  } fus_phase_e;

  localparam logic [7:0] OP_TGT  = 8'h42;
  localparam logic [7:0] OP_CWE  = 8'h44;
  localparam logic [7:0] OP_FWE  = 8'h45;
  localparam logic [7:0] OP_DATA = 8'h47;
  localparam logic [7:0] OP_CRC  = 8'h48;
  localparam logic [7:0] OP_SEQ  = 8'h49;

  localparam logic [7:0] SC_OK       = 8'h01;
  localparam logic [7:0] SC_FAIL     = 8'h02;
  localparam logic [7:0] SC_UNSUP    = 8'h03;
  localparam logic [7:0] SC_ERASE    = 8'h04;
  localparam logic [7:0] SC_WRITE    = 8'h05;
  localparam logic [7:0] SC_READ     = 8'h06;
  localparam logic [7:0] SC_CRCBAD   = 8'h07;
  localparam logic [7:0] SC_BADDEV   = 8'h08;
  localparam logic [7:0] SC_BADLEN   = 8'h0B;
  localparam logic [7:0] SC_DATABUSY = 8'h10;
  localparam logic [7:0] SC_CHKBUSY  = 8'h20;
  localparam logic [7:0] SC_RESEND   = 8'h21;
  localparam logic [7:0] SC_NOTGT    = 8'h23;
  localparam logic [7:0] SC_NOCWE    = 8'h24;
  localparam logic [7:0] SC_NOP      = 8'hFF;

  localparam logic [2:0] RES_OK = 3'd0;
  localparam logic [7:0] MAX_XFER = 8'd252;

  function automatic logic [7:0] res_to_status(input logic [2:0] r);
    case (r)
      3'd0:    res_to_status = SC_OK;
      3'd1:    res_to_status = SC_ERASE;
      3'd2:    res_to_status = SC_WRITE;
      3'd3:    res_to_status = SC_READ;
      3'd4:    res_to_status = SC_CRCBAD;
      3'd5:    res_to_status = SC_RESEND;
      default: res_to_status = SC_FAIL;
    endcase
  endfunction
endpackage

// File: rtl/fus_gate.sv
module fus_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tgt_ld,
  input  logic [7:0] tgt_val,
  input  logic       cwe_ld,
  input  logic       cwe_val,
  input  logic       fwe_ld,
  input  logic       fwe_val,
  output logic [7:0] tgt_o,
  output logic       tgt_set_o,
  output logic       cwe_o,
  output logic       fwe_o
);
  logic [7:0] tgt_q, tgt_d;
  logic       set_q, set_d, cwe_q, cwe_d, fwe_q, fwe_d;

  always_comb begin
    tgt_d = tgt_q;
    set_d = set_q;
    cwe_d = cwe_q;
    fwe_d = fwe_q;
    if (tgt_ld) begin
      tgt_d = tgt_val;
      set_d = 1'b1;
    end
    if (cwe_ld) begin
      cwe_d = cwe_val;
      if (!cwe_val) fwe_d = 1'b0;
    end
    if (fwe_ld) fwe_d = fwe_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= 8'h01;
      set_q <= 1'b0;
      cwe_q <= 1'b0;
      fwe_q <= 1'b0;
    end else begin
      tgt_q <= tgt_d;
      set_q <= set_d;
      cwe_q <= cwe_d;
      fwe_q <= fwe_d;
    end
  end

  assign tgt_o     = tgt_q;
  assign tgt_set_o = set_q;
  assign cwe_o     = cwe_q;
  assign fwe_o     = fwe_q;

  // R4: flash access is never held without controller access
  a_r4_fwe_needs_cwe: assert property (@(posedge clk) disable iff (!rst_n)
    fwe_q |-> cwe_q);
  // R3: controller access is never held without a selected target
  a_r3_cwe_needs_tgt: assert property (@(posedge clk) disable iff (!rst_n)
    cwe_q |-> set_q);
endmodule

// File: rtl/fus_fill.sv
module fus_fill #(
  parameter int SECTOR_BYTES = 65536,
  localparam int FILL_W = $clog2(SECTOR_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              clr,
  output logic [FILL_W-1:0] fill_o,
  output logic              full_o
);
  localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(SECTOR_BYTES);
  logic [FILL_W-1:0] fill_q, fill_d;

  always_comb begin
    fill_d = fill_q;
    if (clr)                         fill_d = '0;
    else if (wr && fill_q != FULL_CNT) fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  assign fill_o = fill_q;
  assign full_o = (fill_q == FULL_CNT);

  // R8: the fill never passes one sector
  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL_CNT);
endmodule

// File: rtl/fus_commit.sv
module fus_commit
  import fus_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int OFF_W = 16,
  localparam int ADDR_W = SEQ_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [63:0]       crc_i,
  input  logic              seq_ld,
  input  logic [SEQ_W-1:0]  seq_val,
  input  logic              wr_done_i,
  input  logic [2:0]        wr_res_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [63:0]       wr_crc_o,
  output logic              done_o,
  output logic [7:0]        done_code_o,
  output logic [SEQ_W-1:0]  seq_o
);
  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [63:0]       crc_q, crc_d;
  logic [SEQ_W-1:0]  seq_q, seq_d;

  assign done_o      = req_q && wr_done_i;
  assign done_code_o = res_to_status(wr_res_i);

  always_comb begin
    req_d  = req_q;
    addr_d = addr_q;
    crc_d  = crc_q;
    seq_d  = seq_q;
    if (start && !req_q) begin
      req_d  = 1'b1;
      addr_d = {seq_q, {OFF_W{1'b0}}};
      crc_d  = crc_i;
    end
    if (done_o) begin
      req_d = 1'b0;
      if (wr_res_i == RES_OK) seq_d = seq_q + 1'b1;
    end
    if (seq_ld && !req_q) seq_d = seq_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      crc_q  <= '0;
      seq_q  <= '0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
      crc_q  <= crc_d;
      seq_q  <= seq_d;
    end
  end

  assign wr_req_o  = req_q;
  assign wr_addr_o = addr_q;
  assign wr_crc_o  = crc_q;
  assign seq_o     = seq_q;

  // R10: request held until the writer answers
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !wr_done_i) |=> req_q);
  // R10: address and CRC stay put during a pending request
  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !wr_done_i) |=> ($stable(addr_q) && $stable(crc_q)));
  // R12: a successful commit advances the sequence number by one
  a_r12_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wr_res_i == RES_OK) |=> (seq_q == $past(seq_q) + 1'b1));
  // R13: the sequence number does not move while a commit is pending
  a_r13_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !wr_done_i) |=> $stable(seq_q));
endmodule

// File: rtl/sector_update_seq.sv
module sector_update_seq
  import fus_pkg::*;
#(
  parameter int SECTOR_BYTES = 65536,
  parameter int SEQ_W = 16,
  localparam int OFF_W = $clog2(SECTOR_BYTES),
  localparam int FILL_W = OFF_W + 1,
  localparam int ADDR_W = SEQ_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start_i,
  input  logic [7:0]        cmd_code_i,
  input  logic [7:0]        cmd_len_i,
  input  logic              pl_valid_i,
  input  logic [7:0]        pl_data_i,
  input  logic              pl_last_i,
  output logic              buf_we_o,
  output logic [OFF_W-1:0]  buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [63:0]       wr_crc_o,
  input  logic              wr_done_i,
  input  logic [2:0]        wr_res_i,
  output logic [7:0]        status_o,
  output logic [7:0]        target_o,
  output logic [SEQ_W-1:0]  seq_o
);
  fus_phase_e  ph_q, ph_d;
  logic [7:0]  idx_q, idx_d, b0_q, b0_d, stat_q, stat_d;
  logic [63:0] crc_q, crc_d, crc_nx;
  logic tgt_ld, cwe_ld, cwe_val, fwe_ld, fwe_val, tgt_set, cwe, fwe;
  logic fill_clr, full, start, seq_ld, done, byte_in;
  logic [7:0] done_code;
  logic [FILL_W-1:0] fill;

  fus_gate u_gate (
    .clk(clk), .rst_n(rst_n), .tgt_ld(tgt_ld), .tgt_val(pl_data_i),
    .cwe_ld(cwe_ld), .cwe_val(cwe_val), .fwe_ld(fwe_ld), .fwe_val(fwe_val),
    .tgt_o(target_o), .tgt_set_o(tgt_set), .cwe_o(cwe), .fwe_o(fwe));

  fus_fill #(.SECTOR_BYTES(SECTOR_BYTES)) u_fill (
    .clk(clk), .rst_n(rst_n), .wr(buf_we_o), .clr(fill_clr),
    .fill_o(fill), .full_o(full));

  fus_commit #(.SEQ_W(SEQ_W), .OFF_W(OFF_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .start(start), .crc_i(crc_nx),
    .seq_ld(seq_ld), .seq_val({pl_data_i, b0_q}),
    .wr_done_i(wr_done_i), .wr_res_i(wr_res_i), .wr_req_o(wr_req_o),
    .wr_addr_o(wr_addr_o), .wr_crc_o(wr_crc_o), .done_o(done),
    .done_code_o(done_code), .seq_o(seq_o));

  assign crc_nx     = {pl_data_i, crc_q[63:8]};
  assign byte_in    = pl_valid_i && !cmd_start_i;
  assign buf_we_o   = byte_in && (ph_q == PH_DATA) && !full;
  assign buf_addr_o = fill[OFF_W-1:0];
  assign buf_data_o = pl_data_i;

  always_comb begin
    ph_d = ph_q; idx_d = idx_q; b0_d = b0_q; crc_d = crc_q; stat_d = stat_q;
    tgt_ld = 1'b0; cwe_ld = 1'b0; cwe_val = 1'b0; fwe_ld = 1'b0;
    fwe_val = 1'b0; fill_clr = 1'b0; start = 1'b0; seq_ld = 1'b0;
    if (done) begin
      stat_d   = done_code;
      fill_clr = 1'b1;
    end
    if (cmd_start_i) begin
      idx_d = '0;
      ph_d  = PH_SKIP;
      if (!wr_req_o) begin
        case (cmd_code_i)
          OP_TGT: ph_d = PH_TGT;
          OP_CWE: ph_d = PH_CWE;
          OP_FWE: ph_d = PH_FWE;
          OP_SEQ: ph_d = PH_SEQ;
          OP_CRC: begin ph_d = PH_CRC; crc_d = '0; end
          OP_DATA: begin
            if (!tgt_set)                                stat_d = SC_NOTGT;
            else if (!cwe)                               stat_d = SC_NOCWE;
            else if (!fwe)                               stat_d = SC_FAIL;
            else if (cmd_len_i == 8'd0 || cmd_len_i > MAX_XFER) stat_d = SC_FAIL;
            else begin
              stat_d = SC_DATABUSY;
              ph_d   = PH_DATA;
            end
          end
          default: stat_d = SC_UNSUP;
        endcase
      end
    end else if (pl_valid_i) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == 8'd0) b0_d = pl_data_i;
      case (ph_q)
        PH_DATA: begin
          if (full) begin
            stat_d = SC_BADLEN; fill_clr = 1'b1; ph_d = PH_SKIP;
          end else if (pl_last_i) stat_d = SC_OK;
        end
        PH_CRC: begin
          crc_d = crc_nx;
          if (pl_last_i) begin
            if (idx_q != 8'd7) stat_d = SC_FAIL;
            else if (!full) begin stat_d = SC_BADLEN; fill_clr = 1'b1; end
            else begin stat_d = SC_CHKBUSY; start = 1'b1; end
          end
        end
        PH_TGT: if (pl_last_i) begin
          if (idx_q != 8'd0) stat_d = SC_FAIL;
          else if (pl_data_i >= 8'h01 && pl_data_i <= 8'h04) begin
            tgt_ld = 1'b1; stat_d = SC_OK;
          end else stat_d = SC_BADDEV;
        end
        PH_CWE, PH_FWE: if (pl_last_i) begin
          if (idx_q != 8'd1)                    stat_d = SC_FAIL;
          else if (!tgt_set)                    stat_d = SC_NOTGT;
          else if (ph_q == PH_FWE && !cwe)      stat_d = SC_NOCWE;
          else if (b0_q != target_o)            stat_d = SC_BADDEV;
          else if (pl_data_i == 8'h01 || pl_data_i == 8'h02) begin
            stat_d  = SC_OK;
            cwe_ld  = (ph_q == PH_CWE);
            fwe_ld  = (ph_q == PH_FWE);
            cwe_val = (pl_data_i == 8'h02);
            fwe_val = (pl_data_i == 8'h02);
          end else stat_d = SC_FAIL;
        end
        PH_SEQ: if (pl_last_i) begin
          if (idx_q != 8'd1) stat_d = SC_FAIL;
          else begin seq_ld = 1'b1; stat_d = SC_OK; end
        end
        default: ;
      endcase
      if (pl_last_i) ph_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      idx_q  <= '0;
      b0_q   <= '0;
      crc_q  <= '0;
      stat_q <= SC_NOP;
    end else begin
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      b0_q   <= b0_d;
      crc_q  <= crc_d;
      stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;

  // R5: no buffer write without the full setup sequence
  a_r5_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_o |-> (tgt_set && cwe && fwe));
  // R13: no buffer write while a commit is pending
  a_r13_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_o |-> !wr_req_o);
  // R9: a commit only starts from a full sector
  a_r9_start_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req_o) |-> full);
  // R10: a commit start reports check in progress
  a_r10_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req_o) |-> (status_o == SC_CHKBUSY));
endmodule

// File: tb/sector_update_seq_bench.sv
module sector_update_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 512;
  localparam int OW = 9;
  localparam int AW = 16 + OW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, pl_valid = 0, pl_last = 0, wr_done = 0;
  logic [7:0] cmd_code = 0, cmd_len = 0, pl_data = 0;
  logic [2:0] wr_res = 0;
  logic buf_we, wr_req;
  logic [OW-1:0] buf_addr;
  logic [7:0] buf_data, status, target;
  logic [AW-1:0] wr_addr;
  logic [63:0] wr_crc;
  logic [15:0] seq;

  int checks = 0, failures = 0, exp_fill = 0;
  logic [7:0] pay [0:259];
  logic [OW+7:0] exp_q [$];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_update_seq #(.SECTOR_BYTES(SB)) u_sector_update_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start), .cmd_code_i(cmd_code),
    .cmd_len_i(cmd_len), .pl_valid_i(pl_valid), .pl_data_i(pl_data),
    .pl_last_i(pl_last), .buf_we_o(buf_we), .buf_addr_o(buf_addr),
    .buf_data_o(buf_data), .wr_req_o(wr_req), .wr_addr_o(wr_addr),
    .wr_crc_o(wr_crc), .wr_done_i(wr_done), .wr_res_i(wr_res),
    .status_o(status), .target_o(target), .seq_o(seq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares every buffer write with the scoreboard queue (R7)
  always @(negedge clk) begin
    if (rst_n && buf_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R7 unexpected write actual=%0h expected=none", {buf_addr, buf_data});
      end else begin
        logic [OW+7:0] e;
        e = exp_q.pop_front();
        if (e !== {buf_addr, buf_data}) begin
          failures++;
          $display("FAIL R7 write actual=%0h expected=%0h", {buf_addr, buf_data}, e);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_cmd(input logic [7:0] code, input logic [7:0] len, input int n);
    cmd_start = 1; cmd_code = code; cmd_len = len;
    tick();
    cmd_start = 0;
    for (int i = 0; i < n; i++) begin
      pl_valid = 1; pl_data = pay[i]; pl_last = (i == n - 1);
      tick();
    end
    pl_valid = 0; pl_last = 0;
  endtask

  task automatic cmd2(input logic [7:0] code, input logic [7:0] a, input logic [7:0] b);
    pay[0] = a; pay[1] = b;
    do_cmd(code, 8'd2, 2);
  endtask

  task automatic data_blk(input int n, input int seed, input bit acc);
    bit ovf = 0;
    for (int i = 0; i < n; i++) begin
      pay[i] = 8'(seed * 7 + i);
      if (acc && !ovf) begin
        if (exp_fill < SB) begin
          exp_q.push_back({OW'(exp_fill), pay[i]});
          exp_fill++;
        end else begin
          ovf = 1; exp_fill = 0;
        end
      end
    end
    do_cmd(8'h47, 8'(n), n);
  endtask

  task automatic fill_sector(input int seed);
    while (exp_fill < SB) begin
      int n;
      n = (SB - exp_fill > 252) ? 252 : SB - exp_fill;
      data_blk(n, seed, 1);
      seed++;
    end
  endtask

  task automatic send_crc(input int n);
    for (int i = 0; i < n; i++) pay[i] = 8'h10 + 8'(i);
    do_cmd(8'h48, 8'(n), n);
  endtask

  task automatic answer(input logic [2:0] r);
    wr_done = 1; wr_res = r;
    tick();
    wr_done = 0; wr_res = 0;
    exp_fill = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 status", status, 8'hFF);
    chk("R1 target", target, 8'h01);
    chk("R1 seq", seq, 0);
    chk("R1 req", wr_req, 0);

    data_blk(4, 1, 0);           chk("R5 no target", status, 8'h23);
    cmd2(8'h44, 8'h01, 8'h02);   chk("R3 no target", status, 8'h23);
    pay[0] = 8'h05; do_cmd(8'h42, 1, 1);
    chk("R2 bad device", status, 8'h08); chk("R2 target kept", target, 8'h01);
    pay[0] = 8'h03; do_cmd(8'h42, 1, 1);
    chk("R2 ok", status, 8'h01); chk("R2 target", target, 8'h03);
    data_blk(4, 1, 0);           chk("R5 no ctl", status, 8'h24);
    cmd2(8'h45, 8'h03, 8'h02);   chk("R4 no ctl", status, 8'h24);
    cmd2(8'h44, 8'h02, 8'h02);   chk("R3 dev mismatch", status, 8'h08);
    cmd2(8'h44, 8'h03, 8'h07);   chk("R3 bad mode", status, 8'h02);
    cmd2(8'h44, 8'h03, 8'h02);   chk("R3 grant", status, 8'h01);
    data_blk(4, 1, 0);           chk("R5 no flash", status, 8'h02);
    cmd2(8'h45, 8'h03, 8'h02);   chk("R4 grant", status, 8'h01);
    do_cmd(8'h47, 8'd0, 0); tick(); chk("R6 zero len", status, 8'h02);
    for (int i = 0; i < 253; i++) pay[i] = 8'hEE;
    do_cmd(8'h47, 8'd253, 253);  chk("R6 too long", status, 8'h02);
    pay[0] = 0; do_cmd(8'hA0, 1, 1); chk("R14 unknown", status, 8'h03);

    // R7 status while streaming
    for (int i = 0; i < 4; i++) begin
      pay[i] = 8'h30 + 8'(i);
      exp_q.push_back({OW'(exp_fill), pay[i]});
      exp_fill++;
    end
    cmd_start = 1; cmd_code = 8'h47; cmd_len = 4; tick(); cmd_start = 0;
    chk("R7 streaming", status, 8'h10);
    for (int i = 0; i < 4; i++) begin
      pl_valid = 1; pl_data = pay[i]; pl_last = (i == 3); tick();
    end
    pl_valid = 0; pl_last = 0;
    chk("R7 done", status, 8'h01);

    send_crc(8); chk("R9 short fill", status, 8'h0B); chk("R9 no req", wr_req, 0);
    exp_fill = 0;
    fill_sector(3); chk("R7 packed", status, 8'h01);
    data_blk(3, 9, 1); chk("R8 overflow", status, 8'h0B);
    fill_sector(11);
    send_crc(7); chk("R9 crc count", status, 8'h02); chk("R9 no req 2", wr_req, 0);
    send_crc(8);
    chk("R10 busy", status, 8'h20); chk("R10 req", wr_req, 1);
    chk("R10 addr", wr_addr, 0); chk("R10 crc", wr_crc, 64'h1716151413121110);
    cmd2(8'h49, 8'h33, 8'h00);
    chk("R13 seq ignored", seq, 0); chk("R13 status kept", status, 8'h20);
    data_blk(4, 5, 0); chk("R13 data ignored", status, 8'h20);
    tick(); chk("R10 hold", wr_req, 1);
    answer(3'd0);
    chk("R11 ok", status, 8'h01); chk("R12 seq step", seq, 1); chk("R10 release", wr_req, 0);

    cmd2(8'h49, 8'h05, 8'h00); chk("R12 load", status, 8'h01); chk("R12 seq", seq, 5);
    pay[0] = 1; do_cmd(8'h49, 1, 1); chk("R12 bad len", status, 8'h02);
    fill_sector(20); send_crc(8);
    chk("R10 addr seq5", wr_addr, AW'(5 * SB));
    answer(3'd4); chk("R11 crc bad", status, 8'h07); chk("R12 seq kept", seq, 5);
    for (int r = 1; r <= 5; r++) begin
      logic [7:0] ec;
      ec = (r == 1) ? 8'h04 : (r == 2) ? 8'h05 : (r == 3) ? 8'h06 :
           (r == 4) ? 8'h07 : 8'h21;
      fill_sector(30 + r); send_crc(8);
      answer(3'(r)); chk("R11 map", status, ec);
    end
    chk("R12 seq after errors", seq, 5);
    cmd2(8'h44, 8'h03, 8'h01); chk("R3 revoke", status, 8'h01);
    data_blk(2, 2, 0); chk("R3 revoked gate", status, 8'h24);
    chk("R7 queue drained", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule